// File: doc/BRIEF.md
# Bridge Memory Window Forwarding Decoder

This block sits in a two-port bus bridge and decides, for each memory transaction seen on either the upstream (primary) or downstream (secondary) bus, whether the bridge claims it and in which direction it goes. It holds two address windows, each set by a base and a limit register.

The first is a memory-mapped I/O window that covers 32-bit addresses only and is sized in 1MB steps. The second is a prefetchable window that can reach across the full 64-bit space. Primary-side accesses inside either window go downstream. Secondary-side accesses outside both windows go upstream, unless the graphics legacy path has already claimed them.

Software programs the windows through a small register port. The command-register memory-enable and master-enable bits arrive as inputs and gate the two directions. The decode is combinational and works from the registered window values. Reads that are forwarded into the prefetchable window are flagged as safe to prefetch.

Top module: `bmw_decoder`

## Requirements
- R1: After reset the I/O window spans 0000_0000h to 000F_FFFFh and the prefetchable window is disabled. Readbacks are 20h=0000h, 22h=0000h, 24h=FFF1h, 26h=0001h, 28h=0, 2Ch=0.
- R2: The register offsets are 20h (I/O base), 22h (I/O limit), 24h (prefetch base), 26h (prefetch limit), 28h (prefetch base upper 32 bits) and 2Ch (prefetch limit upper 32 bits). In the 16-bit registers, bits [15:4] hold address bits [31:20]. Bits [3:0] read 0h for the I/O registers and 1h for the prefetch registers, whatever is written. Writes to any other offset change nothing, and reads of any other offset return 0.
- R3: A single-address-cycle access hits the I/O window when its address lies in {base,00000h} to {limit,FFFFFh}, both ends inclusive.
- R4: A dual-address-cycle access never hits the I/O window.
- R5: The prefetchable window compares {upper32,addr[31:20]} against {base_upper,base} and {limit_upper,limit}. For a single-address-cycle access, upper32 is taken as 0 whatever is on txn_addr[63:32].
- R6: A window whose base is above its limit matches no address.
- R7: A primary-side access that hits either window asserts fwd_down only while mem_en is 1.
- R8: A secondary-side access that misses both windows asserts fwd_up only while mstr_en is 1 and vga_claim is 0.
- R9: A secondary-side hit and a primary-side miss assert neither forwarding output.
- R10: pf_ok is 1 exactly when fwd_down is 1, txn_read is 1 and the prefetchable window is hit.
- R11: With txn_valid at 0, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data at cfg_addr |
| mem_en | input | 1 | Memory enable (gates primary-side claims) |
| mstr_en | input | 1 | Master enable (gates secondary-side claims) |
| txn_valid | input | 1 | A memory transaction is present |
| txn_addr | input | 64 | Transaction address |
| txn_dac | input | 1 | Dual-address-cycle (64-bit) access |
| txn_sec | input | 1 | 1 = seen on the secondary side, 0 = primary side |
| txn_read | input | 1 | Transaction is a memory read |
| vga_claim | input | 1 | Legacy graphics path has claimed the access |
| fwd_down | output | 1 | Claim and forward downstream |
| fwd_up | output | 1 | Claim and forward upstream |
| pf_ok | output | 1 | Forwarded read may be prefetched |

## Verification
The table drives addresses at the exact first and last byte of the I/O window and one byte outside each end, which shows whether the comparison is inclusive and whether the 1MB fill-in is correct. Dual-cycle and single-cycle accesses that share low address bits, together with a single-cycle access that carries junk in the upper word, separate the 32-bit-only I/O window from the 64-bit prefetch compare and show that the upper word is forced to zero. Each address is tried from both sides, and with the graphics claim, to show the inversion of the decision on the secondary side. Directed cases then clear each enable, invert each window, and write the read-only nibbles and an unused offset.

// File: rtl/bmw_pkg.sv
package bmw_pkg;
  localparam int LOW_W   = 32;
  localparam int GRAN_SH = 20;
  localparam int FLD_W   = LOW_W - GRAN_SH;
  localparam int UP_W    = 32;
  localparam int PF_W    = UP_W + FLD_W;

  localparam logic [7:0] OFF_IO_BASE = 8'h20;
  localparam logic [7:0] OFF_IO_LIM  = 8'h22;
  localparam logic [7:0] OFF_PF_BASE = 8'h24;
  localparam logic [7:0] OFF_PF_LIM  = 8'h26;
  localparam logic [7:0] OFF_PF_BUP  = 8'h28;
  localparam logic [7:0] OFF_PF_LUP  = 8'h2C;

  localparam logic [3:0] IO_TAG = 4'h0;
  localparam logic [3:0] PF_TAG = 4'h1;

  typedef struct packed {
    logic [FLD_W-1:0] io_base;
    logic [FLD_W-1:0] io_lim;
    logic [FLD_W-1:0] pf_base;
    logic [FLD_W-1:0] pf_lim;
    logic [UP_W-1:0]  pf_bup;
    logic [UP_W-1:0]  pf_lup;
  } win_cfg_t;

  function automatic logic [PF_W-1:0] pf_key(input logic [63:0] a, input logic dac);
    logic [UP_W-1:0] hi;
    hi = dac ? a[63:32] : '0;
    return {hi, a[LOW_W-1:GRAN_SH]};
  endfunction

  function automatic logic [15:0] fld_view(input logic [FLD_W-1:0] f, input logic [3:0] tag);
    return {f, tag};
  endfunction
endpackage

// File: rtl/bmw_cfg_regs.sv
module bmw_cfg_regs
  import bmw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output win_cfg_t    win
);
  win_cfg_t win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q.io_base <= '0;
      win_q.io_lim  <= '0;
      win_q.pf_base <= '1;
      win_q.pf_lim  <= '0;
      win_q.pf_bup  <= '0;
      win_q.pf_lup  <= '0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        OFF_IO_BASE: win_q.io_base <= cfg_wdata[15:4];
        OFF_IO_LIM:  win_q.io_lim  <= cfg_wdata[15:4];
        OFF_PF_BASE: win_q.pf_base <= cfg_wdata[15:4];
        OFF_PF_LIM:  win_q.pf_lim  <= cfg_wdata[15:4];
        OFF_PF_BUP:  win_q.pf_bup  <= cfg_wdata;
        OFF_PF_LUP:  win_q.pf_lup  <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      OFF_IO_BASE: cfg_rdata = {16'h0, fld_view(win_q.io_base, IO_TAG)};
      OFF_IO_LIM:  cfg_rdata = {16'h0, fld_view(win_q.io_lim,  IO_TAG)};
      OFF_PF_BASE: cfg_rdata = {16'h0, fld_view(win_q.pf_base, PF_TAG)};
      OFF_PF_LIM:  cfg_rdata = {16'h0, fld_view(win_q.pf_lim,  PF_TAG)};
      OFF_PF_BUP:  cfg_rdata = win_q.pf_bup;
      OFF_PF_LUP:  cfg_rdata = win_q.pf_lup;
      default:     cfg_rdata = '0;
    endcase
  end

  assign win = win_q;

  wire io_sel = (cfg_addr == OFF_IO_BASE) || (cfg_addr == OFF_IO_LIM);
  wire pf_sel = (cfg_addr == OFF_PF_BASE) || (cfg_addr == OFF_PF_LIM);

  AST_IO_RO_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel |-> cfg_rdata[3:0] == 4'h0); // R2
  AST_PF_RO_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_sel |-> cfg_rdata[3:0] == 4'h1); // R2
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !io_sel && !pf_sel && cfg_addr != OFF_PF_BUP && cfg_addr != OFF_PF_LUP)
      |=> $stable(win_q)); // R2
endmodule

// File: rtl/bmw_window_match.sv
module bmw_window_match #(
  parameter int CMP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMP_W-1:0] key,
  input  logic [CMP_W-1:0] base,
  input  logic [CMP_W-1:0] lim,
  output logic             hit,
  output logic             win_off
);
  logic above_base, below_lim;

  always_comb begin
    above_base = (key >= base);
    below_lim  = (key <= lim);
    win_off    = (base > lim);
    hit        = above_base && below_lim;
  end

  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    win_off |-> !hit); // R6
  AST_EDGE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (key == base && !win_off) |-> hit); // R3
endmodule

// File: rtl/bmw_decoder.sv
module bmw_decoder
  import bmw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        mem_en,
  input  logic        mstr_en,
  input  logic        txn_valid,
  input  logic [63:0] txn_addr,
  input  logic        txn_dac,
  input  logic        txn_sec,
  input  logic        txn_read,
  input  logic        vga_claim,
  output logic        fwd_down,
  output logic        fwd_up,
  output logic        pf_ok
);
  win_cfg_t win;

  bmw_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .win(win)
  );

  logic [FLD_W-1:0] io_key;
  logic [PF_W-1:0]  pf_key_w, pf_base_w, pf_lim_w;
  logic io_win_hit, io_off, pf_hit, pf_off;

  assign io_key    = txn_addr[LOW_W-1:GRAN_SH];
  assign pf_key_w  = pf_key(txn_addr, txn_dac);
  assign pf_base_w = {win.pf_bup, win.pf_base};
  assign pf_lim_w  = {win.pf_lup, win.pf_lim};

  bmw_window_match #(.CMP_W(FLD_W)) u_io_match (
    .clk(clk), .rst_n(rst_n), .key(io_key), .base(win.io_base), .lim(win.io_lim),
    .hit(io_win_hit), .win_off(io_off)
  );

  bmw_window_match #(.CMP_W(PF_W)) u_pf_match (
    .clk(clk), .rst_n(rst_n), .key(pf_key_w), .base(pf_base_w), .lim(pf_lim_w),
    .hit(pf_hit), .win_off(pf_off)
  );

  logic io_hit, any_hit, claim_down, claim_up;

  always_comb begin
    io_hit     = io_win_hit && !txn_dac;
    any_hit    = io_hit || pf_hit;
    claim_down = txn_valid && !txn_sec && any_hit;
    claim_up   = txn_valid && txn_sec && !any_hit && !vga_claim;
    fwd_down   = claim_down && mem_en;
    fwd_up     = claim_up && mstr_en;
    pf_ok      = fwd_down && txn_read && pf_hit;
  end

  AST_IO_DAC_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_dac) |-> !io_hit); // R4
  AST_SAC_PF_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_dac && pf_hit) |-> (win.pf_bup == '0)); // R5
  AST_DOWN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_down |-> (mem_en && !txn_sec)); // R7
  AST_UP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_up |-> (mstr_en && !vga_claim && !io_win_hit && !pf_hit) || (fwd_up && txn_dac && !pf_hit)); // R8
  AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_down && fwd_up)); // R9
  AST_PF_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pf_ok |-> (txn_read && !pf_off && fwd_down)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_valid |-> (!fwd_down && !fwd_up && !pf_ok)); // R11
  AST_IO_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (io_off && pf_off && !txn_sec) |-> !fwd_down); // R6
endmodule

// File: tb/bmw_decoder_tb.sv
module bmw_decoder_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0;
  logic [7:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic mem_en = 0, mstr_en = 0, txn_valid = 0, txn_dac = 0, txn_sec = 0, txn_read = 0, vga_claim = 0;
  logic [63:0] txn_addr = 0;
  logic fwd_down, fwd_up, pf_ok;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  bmw_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mem_en(mem_en), .mstr_en(mstr_en), .txn_valid(txn_valid),
    .txn_addr(txn_addr), .txn_dac(txn_dac), .txn_sec(txn_sec), .txn_read(txn_read),
    .vga_claim(vga_claim), .fwd_down(fwd_down), .fwd_up(fwd_up), .pf_ok(pf_ok)
  );

  typedef struct packed {
    logic [63:0] addr;
    logic dac, sec, rd, vga;
    logic e_down, e_up, e_pf;
  } vec_t;

  // Window after setup: I/O 1000_0000..10FF_FFFF, prefetch 0_8000_0000..1_8FFF_FFFF
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0000_1000_0000, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0}, // R3 low edge
    '{64'h0000_0000_10FF_FFFF, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0}, // R3 high edge
    '{64'h0000_0000_0FFF_FFFF, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0}, // R9 below
    '{64'h0000_0000_1100_0000, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0}, // R9 above
    '{64'h0000_0000_1000_0000, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0}, // R4 dac
    '{64'h0000_0001_1000_0000, 1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b1}, // R5 R10
    '{64'h0000_0000_8000_0000, 1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b1}, // R5 R10
    '{64'h0000_0005_9000_0000, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0}, // R5 sac upper ignored
    '{64'h0000_0001_9000_0000, 1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0}, // R5 above limit
    '{64'h0000_0000_2000_0000, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0}, // R8
    '{64'h0000_0000_1000_0000, 1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0}, // R9 sec hit
    '{64'h0000_0000_2000_0000, 1'b0,1'b1,1'b0,1'b1, 1'b0,1'b0,1'b0}, // R8 vga
    '{64'h0000_0001_0000_0000, 1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0}, // R9 sec pf hit
    '{64'h0000_0002_0000_0000, 1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0}  // R8 dac miss
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0; cfg_wdata = 0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic txn(input logic [63:0] a, input logic dac, input logic sec, input logic rd, input logic vga);
    @(negedge clk);
    txn_valid = 1; txn_addr = a; txn_dac = dac; txn_sec = sec; txn_read = rd; vga_claim = vga;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset readbacks
    cfg_read(8'h20, rd); chk("R1 io base", rd, 32'h0000);
    cfg_read(8'h22, rd); chk("R1 io lim", rd, 32'h0000);
    cfg_read(8'h24, rd); chk("R1 pf base", rd, 32'hFFF1);
    cfg_read(8'h26, rd); chk("R1 pf lim", rd, 32'h0001);
    cfg_read(8'h28, rd); chk("R1 pf bup", rd, 32'h0);
    cfg_read(8'h2C, rd); chk("R1 pf lup", rd, 32'h0);
    mem_en = 1; mstr_en = 1;
    txn(64'h0000_0000_000F_FFFF, 0, 0, 1, 0);
    chk("R1 reset io top", {fwd_down, fwd_up, pf_ok}, 3'b100);
    txn(64'h0000_0000_0010_0000, 0, 0, 1, 0);
    chk("R1 reset io above", {fwd_down, fwd_up, pf_ok}, 3'b000);
    txn(64'h0000_0000_FFF0_0000, 0, 0, 1, 0);
    chk("R1 reset pf off", {fwd_down, fwd_up, pf_ok}, 3'b000);

    // R11 idle
    @(negedge clk); txn_valid = 0; #1;
    chk("R11 idle", {fwd_down, fwd_up, pf_ok}, 3'b000);

    // R2 register map and read-only nibbles
    cfg_write(8'h20, 32'h0000_100F);
    cfg_write(8'h22, 32'h0000_10FA);
    cfg_write(8'h24, 32'h0000_8000);
    cfg_write(8'h26, 32'h0000_8FFE);
    cfg_write(8'h28, 32'h0);
    cfg_write(8'h2C, 32'h1);
    cfg_write(8'h30, 32'hFFFF_FFFF);
    cfg_write(8'h2A, 32'hFFFF_FFFF);
    cfg_read(8'h20, rd); chk("R2 io base ro", rd, 32'h1000);
    cfg_read(8'h22, rd); chk("R2 io lim ro", rd, 32'h10F0);
    cfg_read(8'h24, rd); chk("R2 pf base ro", rd, 32'h8001);
    cfg_read(8'h26, rd); chk("R2 pf lim ro", rd, 32'h8FF1);
    cfg_read(8'h2C, rd); chk("R2 pf lup", rd, 32'h1);
    cfg_read(8'h28, rd); chk("R2 stray write", rd, 32'h0);
    cfg_read(8'h30, rd); chk("R2 unmapped read", rd, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      txn(VECS[i].addr, VECS[i].dac, VECS[i].sec, VECS[i].rd, VECS[i].vga);
      chk($sformatf("R3-table vec%0d", i), {fwd_down, fwd_up, pf_ok},
          {VECS[i].e_down, VECS[i].e_up, VECS[i].e_pf});
    end

    // R7 memory enable gating
    mem_en = 0;
    txn(64'h0000_0000_1000_0000, 0, 0, 1, 0);
    chk("R7 mem_en off", {fwd_down, fwd_up, pf_ok}, 3'b000);
    mem_en = 1;
    txn(64'h0000_0000_8000_0000, 0, 0, 0, 0);
    chk("R7 pf write down", {fwd_down, fwd_up, pf_ok}, 3'b100);
    chk("R10 write no prefetch", pf_ok, 1'b0);

    // R8 master enable gating
    mstr_en = 0;
    txn(64'h0000_0000_2000_0000, 0, 1, 0, 0);
    chk("R8 mstr_en off", {fwd_down, fwd_up, pf_ok}, 3'b000);
    mstr_en = 1;

    // R6 windows disabled by base above limit
    cfg_write(8'h20, 32'h0000_2000);
    cfg_write(8'h22, 32'h0000_1FF0);
    txn(64'h0000_0000_1FF0_0000, 0, 0, 0, 0);
    chk("R6 io off low", {fwd_down, fwd_up, pf_ok}, 3'b000);
    txn(64'h0000_0000_2000_0000, 0, 1, 0, 0);
    chk("R6 io off sec fwd up", {fwd_down, fwd_up, pf_ok}, 3'b010);
    cfg_write(8'h28, 32'h2);
    txn(64'h0000_0001_8000_0000, 1, 0, 1, 0);
    chk("R6 pf off", {fwd_down, fwd_up, pf_ok}, 3'b000);
    txn(64'h0000_0000_8000_0000, 0, 0, 1, 0);
    chk("R5 sac needs zero upper base", {fwd_down, fwd_up, pf_ok}, 3'b000);

    @(negedge clk); txn_valid = 0; #1;
    chk("R11 idle end", {fwd_down, fwd_up, pf_ok}, 3'b000);
    finish_run();
  end
endmodule